// File: doc/BRIEF.md
# Persist Write Buffer for a Fabric Switch

This block sits in a fabric switch on the path from requesters to remote persistent memory. Each accepted write is captured in a small fully-associative array of entries. Every entry holds an address tag, a line of data, a two-bit state and a four-bit recency age. The write is acknowledged upstream on the cycle after capture. The requester does not wait for the remote memory.

Entries drain to the downstream memory port in the background, one at a time and oldest allocation first. A write to a line that is still waiting to drain is merged into that entry. A write to a line that is already draining takes a fresh entry, so the newer data lands behind the in-flight copy. Reads that match a buffered line are answered from the buffer. When the array is full, or while a flush is requested and lines remain, new writes are held off.

Top module: `persist_wbuf`

## Requirements
- R1: After reset every entry is Empty: `wr_ready_o`=1, `dn_valid_o`=0, `wr_ack_o`=0, and a read of any address returns `rd_hit_o`=0 with `rd_data_o`=0.
- R2: For each write accepted on a clock edge (`wr_valid_i` and `wr_ready_o` both 1), `wr_ack_o` is 1 for the following cycle, whatever `dn_ack_i` does. `wr_ack_o` is 0 in any other cycle.
- R3: A write whose address equals that of an entry in the Dirty state (code 1), which is not being handed downstream in the same cycle, replaces that entry's data. No new entry is allocated, so the address is sent downstream only once, with the last data.
- R4: A write whose address equals that of an entry in the Drain state (code 2) allocates a new Dirty entry. The new data is sent downstream after the draining copy.
- R5: At most one entry is in the Drain state at a time. While `dn_valid_o` is 1 and `dn_ack_i` is 0, `dn_addr_o` and `dn_data_o` stay stable. On `dn_ack_i` the entry returns to Empty (code 0).
- R6: Entries are sent downstream in the order in which they were allocated. A merge does not change an entry's position.
- R7: `rd_resp_o` is 1 in the cycle after `rd_valid_i`. `rd_hit_o` is 1 when a Dirty or Drain entry holds the address. `rd_data_o` returns the Dirty entry's data in preference to the Drain entry's data, and is 0 on a miss.
- R8: `wr_ready_o` is 0 whenever no entry is Empty. A write offered then is neither acknowledged nor stored.
- R9: While `flush_i` is 1 and any entry is non-empty, `wr_ready_o` is 0 and the buffer keeps draining. Once all entries are Empty, `wr_ready_o` returns to 1 even while `flush_i` is still held.
- R10: Entry ages always form a permutation of 0..NUM_ENT-1. A write or a read hit makes the touched entry's age 0. Allocation takes the Empty entry with the largest age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Buffer can take a write |
| wr_addr_i | input | ADDR_W | Write line address |
| wr_data_i | input | LINE_BYTES*8 | Write line data |
| wr_ack_o | output | 1 | Early durable acknowledgement |
| flush_i | input | 1 | Hold writes until all entries have drained |
| rd_valid_i | input | 1 | Read lookup request |
| rd_addr_i | input | ADDR_W | Read line address |
| rd_resp_o | output | 1 | Read lookup result valid |
| rd_hit_o | output | 1 | Line was found in the buffer |
| rd_data_o | output | LINE_BYTES*8 | Forwarded line data |
| dn_valid_o | output | 1 | Downstream write outstanding |
| dn_addr_o | output | ADDR_W | Downstream write address |
| dn_data_o | output | LINE_BYTES*8 | Downstream write data |
| dn_ack_i | input | 1 | Downstream write completed |

## Verification
The bench builds the buffer with NUM_ENT=4, ADDR_W=16 and LINE_BYTES=16. With only four entries, a handful of writes issued while downstream acknowledgements are withheld fills the array. That makes the full-stall path, the release on a single drain, and a complete FIFO replay of every entry reachable in a short run. The 16-byte line keeps the data compare wide enough to tell merged data from stale data.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int AGE_W = 4;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_DIRTY = 2'd1,
    ST_DRAIN = 2'd2
  } ent_state_e;
endpackage

// File: rtl/pwb_match.sv
module pwb_match #(
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  pwb_pkg::ent_state_e         st_i   [NUM_ENT],
  input  logic [ADDR_W-1:0]           tag_i  [NUM_ENT],
  input  logic [pwb_pkg::AGE_W-1:0]   age_i  [NUM_ENT],
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        excl_vld_i,
  input  logic [IDX_W-1:0]            excl_idx_i,
  output logic                        dirty_hit_o,
  output logic [IDX_W-1:0]            dirty_idx_o,
  output logic                        drain_hit_o,
  output logic [IDX_W-1:0]            drain_idx_o,
  output logic                        free_any_o,
  output logic [IDX_W-1:0]            free_idx_o
);
  import pwb_pkg::*;

  logic [AGE_W-1:0] best_age;

  always_comb begin
    dirty_hit_o = 1'b0;
    dirty_idx_o = '0;
    drain_hit_o = 1'b0;
    drain_idx_o = '0;
    free_any_o  = 1'b0;
    free_idx_o  = '0;
    best_age    = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (st_i[i] == ST_DIRTY && tag_i[i] == addr_i &&
          !(excl_vld_i && excl_idx_i == IDX_W'(i))) begin
        dirty_hit_o = 1'b1;
        dirty_idx_o = IDX_W'(i);
      end
      if (st_i[i] == ST_DRAIN && tag_i[i] == addr_i) begin
        drain_hit_o = 1'b1;
        drain_idx_o = IDX_W'(i);
      end
      // least recently used empty entry wins
      if (st_i[i] == ST_EMPTY && (!free_any_o || age_i[i] > best_age)) begin
        free_any_o = 1'b1;
        free_idx_o = IDX_W'(i);
        best_age   = age_i[i];
      end
    end
  end
endmodule

// File: rtl/pwb_lru.sv
module pwb_lru #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      touch_i,
  input  logic [IDX_W-1:0]          touch_idx_i,
  output logic [pwb_pkg::AGE_W-1:0] age_o [NUM_ENT]
);
  import pwb_pkg::*;

  logic [AGE_W-1:0] age_q [NUM_ENT];
  logic [AGE_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx_i];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= AGE_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))  age_q[g] <= '0;
        else if (age_q[g] < ref_age)   age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign age_o[g] = age_q[g];
  end
endmodule

// File: rtl/pwb_order_fifo.sv
module pwb_order_fifo #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic             nonempty_o
);
  localparam int CNT_W = $clog2(NUM_ENT + 1);

  logic [IDX_W-1:0] slot_q [NUM_ENT];
  logic [IDX_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < NUM_ENT; i++) slot_q[i] <= '0;
    end else begin
      if (push_i) begin
        slot_q[wr_ptr_q] <= push_idx_i;
        wr_ptr_q         <= bump(wr_ptr_q);
      end
      if (pop_i) rd_ptr_q <= bump(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o     = slot_q[rd_ptr_q];
  assign nonempty_o = (cnt_q != '0);
endmodule

// File: rtl/persist_wbuf.sv
module persist_wbuf #(
  parameter int NUM_ENT    = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_valid_i,
  output logic                    wr_ready_o,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LINE_BYTES*8-1:0] wr_data_i,
  output logic                    wr_ack_o,
  input  logic                    flush_i,
  input  logic                    rd_valid_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic                    rd_resp_o,
  output logic                    rd_hit_o,
  output logic [LINE_BYTES*8-1:0] rd_data_o,
  output logic                    dn_valid_o,
  output logic [ADDR_W-1:0]       dn_addr_o,
  output logic [LINE_BYTES*8-1:0] dn_data_o,
  input  logic                    dn_ack_i
);
  import pwb_pkg::*;

  localparam int DATA_W = LINE_BYTES * 8;
  localparam int IDX_W  = $clog2(NUM_ENT);

  ent_state_e       st_q   [NUM_ENT];
  logic [ADDR_W-1:0] tag_q  [NUM_ENT];
  logic [DATA_W-1:0] data_q [NUM_ENT];
  logic [AGE_W-1:0]  age    [NUM_ENT];

  logic             busy_q;
  logic [IDX_W-1:0] cur_q;
  logic             ack_q, rd_resp_q, rd_hit_q;
  logic [DATA_W-1:0] rd_data_q;

  logic             fifo_ne;
  logic [IDX_W-1:0] head_idx;
  logic             issue, wr_fire, merge, any_busy_ent;

  logic             w_dirty_hit, w_free_any;
  logic [IDX_W-1:0] w_dirty_idx, w_free_idx;
  logic             w_drain_hit_unused;
  logic [IDX_W-1:0] w_drain_idx_unused;

  logic             r_dirty_hit, r_drain_hit;
  logic [IDX_W-1:0] r_dirty_idx, r_drain_idx;
  logic             r_free_any_unused;
  logic [IDX_W-1:0] r_free_idx_unused;

  logic             touch;
  logic [IDX_W-1:0] touch_idx;
  logic [DATA_W-1:0] rd_data_d;

  // entry picked for drain this cycle must not absorb a merge
  assign issue = !busy_q && fifo_ne;

  pwb_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wmatch (
    .st_i(st_q), .tag_i(tag_q), .age_i(age), .addr_i(wr_addr_i),
    .excl_vld_i(issue), .excl_idx_i(head_idx),
    .dirty_hit_o(w_dirty_hit), .dirty_idx_o(w_dirty_idx),
    .drain_hit_o(w_drain_hit_unused), .drain_idx_o(w_drain_idx_unused),
    .free_any_o(w_free_any), .free_idx_o(w_free_idx)
  );

  pwb_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rmatch (
    .st_i(st_q), .tag_i(tag_q), .age_i(age), .addr_i(rd_addr_i),
    .excl_vld_i(1'b0), .excl_idx_i('0),
    .dirty_hit_o(r_dirty_hit), .dirty_idx_o(r_dirty_idx),
    .drain_hit_o(r_drain_hit), .drain_idx_o(r_drain_idx),
    .free_any_o(r_free_any_unused), .free_idx_o(r_free_idx_unused)
  );

  always_comb begin
    any_busy_ent = 1'b0;
    for (int i = 0; i < NUM_ENT; i++)
      if (st_q[i] != ST_EMPTY) any_busy_ent = 1'b1;
  end

  assign wr_ready_o = w_free_any && !(flush_i && any_busy_ent);
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign merge      = w_dirty_hit;

  pwb_order_fifo #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_order (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(wr_fire && !merge), .push_idx_i(w_free_idx),
    .pop_i(issue), .head_o(head_idx), .nonempty_o(fifo_ne)
  );

  always_comb begin
    touch     = 1'b0;
    touch_idx = '0;
    if (wr_fire) begin
      touch     = 1'b1;
      touch_idx = merge ? w_dirty_idx : w_free_idx;
    end else if (rd_valid_i && (r_dirty_hit || r_drain_hit)) begin
      touch     = 1'b1;
      touch_idx = r_dirty_hit ? r_dirty_idx : r_drain_idx;
    end
  end

  pwb_lru #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_i(touch), .touch_idx_i(touch_idx), .age_o(age)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]   <= ST_EMPTY;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else begin
        if (busy_q && dn_ack_i && cur_q == IDX_W'(g)) st_q[g] <= ST_EMPTY;
        if (issue && head_idx == IDX_W'(g))           st_q[g] <= ST_DRAIN;
        if (wr_fire) begin
          if (merge && w_dirty_idx == IDX_W'(g)) begin
            data_q[g] <= wr_data_i;
          end else if (!merge && w_free_idx == IDX_W'(g)) begin
            st_q[g]   <= ST_DIRTY;
            tag_q[g]  <= wr_addr_i;
            data_q[g] <= wr_data_i;
          end
        end
      end
    end
  end

  always_comb begin
    if (r_dirty_hit)      rd_data_d = data_q[r_dirty_idx];
    else if (r_drain_hit) rd_data_d = data_q[r_drain_idx];
    else                  rd_data_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cur_q     <= '0;
      ack_q     <= 1'b0;
      rd_resp_q <= 1'b0;
      rd_hit_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      ack_q     <= wr_fire;
      rd_resp_q <= rd_valid_i;
      if (rd_valid_i) begin
        rd_hit_q  <= r_dirty_hit || r_drain_hit;
        rd_data_q <= rd_data_d;
      end
      if (issue) begin
        busy_q <= 1'b1;
        cur_q  <= head_idx;
      end else if (busy_q && dn_ack_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign wr_ack_o   = ack_q;
  assign rd_resp_o  = rd_resp_q;
  assign rd_hit_o   = rd_hit_q;
  assign rd_data_o  = rd_data_q;
  assign dn_valid_o = busy_q;
  assign dn_addr_o  = tag_q[cur_q];
  assign dn_data_o  = data_q[cur_q];
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 128
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_valid_i,
  input logic                      wr_ready_o,
  input logic                      wr_ack_o,
  input logic                      flush_i,
  input logic                      rd_valid_i,
  input logic                      rd_resp_o,
  input logic                      dn_valid_o,
  input logic                      dn_ack_i,
  input logic [ADDR_W-1:0]         dn_addr_o,
  input logic [DATA_W-1:0]         dn_data_o,
  input pwb_pkg::ent_state_e       st_i  [NUM_ENT],
  input logic [pwb_pkg::AGE_W-1:0] age_i [NUM_ENT]
);
  import pwb_pkg::*;

  int unsigned n_empty, n_drain;
  logic [(1<<AGE_W)-1:0] age_seen;

  always_comb begin
    n_empty  = 0;
    n_drain  = 0;
    age_seen = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (st_i[i] == ST_EMPTY) n_empty++;
      if (st_i[i] == ST_DRAIN) n_drain++;
      age_seen[age_i[i]] = 1'b1;
    end
  end

  AST_ACK_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o |=> wr_ack_o); // R2
  AST_NO_STRAY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_i && wr_ready_o) |=> !wr_ack_o); // R2
  AST_DN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ack_i |=> dn_valid_o && $stable(dn_addr_o) && $stable(dn_data_o)); // R5
  AST_ONE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_drain <= 1 && (dn_valid_o == (n_drain == 1))); // R5
  AST_STALL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_empty == 0 |-> !wr_ready_o); // R8
  AST_FLUSH_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && n_empty != NUM_ENT |-> !wr_ready_o); // R9
  AST_RD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_resp_o); // R7
  AST_LRU_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(age_seen) == NUM_ENT); // R10
endmodule

bind persist_wbuf pwb_checker #(
  .NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .DATA_W(LINE_BYTES*8)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .wr_ack_o(wr_ack_o), .flush_i(flush_i), .rd_valid_i(rd_valid_i), .rd_resp_o(rd_resp_o),
  .dn_valid_o(dn_valid_o), .dn_ack_i(dn_ack_i), .dn_addr_o(dn_addr_o), .dn_data_o(dn_data_o),
  .st_i(st_q), .age_i(age)
);

// File: tb/persist_wbuf_tb_top.sv
module persist_wbuf_tb_top;
  localparam int NE = 4;
  localparam int AW = 16;
  localparam int DW = 128;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DR = 2'd2, OP_ID = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] val;
    logic        hit;
  } vec_t;

  // R3 merge (2), R4 drain-hit realloc (5, 10), R6 order (8..10), R7 forwarding
  localparam vec_t VECS [13] = '{
    '{OP_WR, 16'h0010, 32'h1, 1'b0},
    '{OP_WR, 16'h0020, 32'h2, 1'b0},
    '{OP_WR, 16'h0020, 32'h5, 1'b0},
    '{OP_RD, 16'h0020, 32'h5, 1'b1},
    '{OP_RD, 16'h0010, 32'h1, 1'b1},
    '{OP_WR, 16'h0010, 32'h7, 1'b0},
    '{OP_RD, 16'h0010, 32'h7, 1'b1},
    '{OP_RD, 16'h0030, 32'h0, 1'b0},
    '{OP_DR, 16'h0010, 32'h1, 1'b0},
    '{OP_DR, 16'h0020, 32'h5, 1'b0},
    '{OP_DR, 16'h0010, 32'h7, 1'b0},
    '{OP_ID, 16'h0000, 32'h0, 1'b0},
    '{OP_RD, 16'h0010, 32'h0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, flush = 1'b0, rd_valid = 1'b0, dn_ack = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, wr_ack, rd_resp, rd_hit, dn_valid;
  logic [DW-1:0] rd_data, dn_data;
  logic [AW-1:0] dn_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  persist_wbuf #(.NUM_ENT(NE), .ADDR_W(AW), .LINE_BYTES(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_ack_o(wr_ack), .flush_i(flush),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_resp_o(rd_resp),
    .rd_hit_o(rd_hit), .rd_data_o(rd_data),
    .dn_valid_o(dn_valid), .dn_addr_o(dn_addr), .dn_data_o(dn_data), .dn_ack_i(dn_ack)
  );

  function automatic logic [DW-1:0] line(input logic [31:0] v);
    return {4{v}};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] v);
    wr_valid = 1'b1; wr_addr = a; wr_data = line(v);
    @(negedge clk);
    chk(wr_ack == 1'b1, "R2 ack after write", DW'(wr_ack), DW'(1));
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic h, input logic [31:0] v);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_resp == 1'b1, "R7 resp", DW'(rd_resp), DW'(1));
    chk(rd_hit == h, "R7 hit", DW'(rd_hit), DW'(h));
    chk(rd_data == (h ? line(v) : '0), "R7 data", rd_data, h ? line(v) : '0);
  endtask

  task automatic do_drain(input logic [AW-1:0] a, input logic [31:0] v);
    while (!dn_valid) @(negedge clk);
    chk(dn_addr == a, "R6 drain addr", DW'(dn_addr), DW'(a));
    chk(dn_data == line(v), "R5 drain data", dn_data, line(v));
    dn_ack = 1'b1;
    @(negedge clk);
    dn_ack = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_ready == 1'b1, "R1 ready", DW'(wr_ready), DW'(1));
    chk(dn_valid == 1'b0, "R1 dn_valid", DW'(dn_valid), DW'(0));
    chk(wr_ack == 1'b0, "R1 ack", DW'(wr_ack), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'h0010, 1'b0, 32'h0);

    for (int i = 0; i < 13; i++) begin
      case (VECS[i].op)
        OP_WR: do_write(VECS[i].addr, VECS[i].val);
        OP_RD: do_read(VECS[i].addr, VECS[i].hit, VECS[i].val);
        OP_DR: do_drain(VECS[i].addr, VECS[i].val);
        default: begin
          repeat (3) @(negedge clk);
          chk(dn_valid == 1'b0, "R3 no duplicate drain", DW'(dn_valid), DW'(0));
        end
      endcase
    end

    // R8 full stall with drains withheld
    for (int k = 0; k < NE; k++) do_write(AW'(16'h0100 + k), 32'h100 + k);
    chk(wr_ready == 1'b0, "R8 ready low when full", DW'(wr_ready), DW'(0));
    wr_valid = 1'b1; wr_addr = 16'h0104; wr_data = line(32'h104);
    repeat (2) @(negedge clk);
    chk(wr_ack == 1'b0, "R8 no ack while full", DW'(wr_ack), DW'(0));
    wr_valid = 1'b0;
    do_drain(16'h0100, 32'h100);
    chk(wr_ready == 1'b1, "R8 ready after drain", DW'(wr_ready), DW'(1));
    do_write(16'h0104, 32'h104);
    // R6 full FIFO replay
    for (int k = 1; k <= NE; k++) do_drain(AW'(16'h0100 + k), 32'h100 + k);

    // R9 flush gate
    do_write(16'h0200, 32'h200);
    do_write(16'h0201, 32'h201);
    flush = 1'b1;
    #1;
    chk(wr_ready == 1'b0, "R9 ready low during flush", DW'(wr_ready), DW'(0));
    do_drain(16'h0200, 32'h200);
    do_drain(16'h0201, 32'h201);
    chk(wr_ready == 1'b1, "R9 ready once empty", DW'(wr_ready), DW'(1));
    flush = 1'b0;

    // R1 reset clears buffered lines
    do_write(16'h0300, 32'h300);
    rst_n = 1'b0;
    @(negedge clk);
    chk(dn_valid == 1'b0, "R1 dn_valid in reset", DW'(dn_valid), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'h0300, 1'b0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule